// File: doc/BRIEF.md
# LCD Dot and Shift Clock Rate Generator

This block produces the pixel-rate timing strobes for an LCD controller inside a single reference clock domain. Each of the three candidate clock sources (bus, peripheral, external) arrives as a one-cycle clock-enable input. A 16-bit control register chooses one source and an integer divide ratio from 1 to 16. The block counts enables from the chosen source and emits a one-cycle dot strobe once per ratio period.

The panel shift strobe is derived from the dot strobe. The rule depends on static configuration inputs: the panel kind (TFT, monochrome STN, colour STN) and the panel data bus width (4, 8 or 16). A TFT panel shifts once per dot. A monochrome STN panel shifts once for every bus-width dots. A colour STN panel shifts at three times that rate on average. The STN rates come from an accumulator that adds the per-dot weight and fires when the sum reaches the bus width.

The block reports out-of-range divide settings and writes of the prohibited source code on two flag outputs. Any change of source or divide ratio restarts the counters, so no partial period is emitted.

Top module: `lcd_dotclk_gen`

## Requirements
- R1: After reset, reg_rdata reads 16'h1001 (source code 01 = peripheral, divide field 1), and dot_stb, shift_stb, div_range_err and src_code_err are low.
- R2: A write stores source code bits [13:12] and divide field bits [4:0]. reg_rdata returns them in those positions. Bits [15:14] and [11:5] always read zero, whatever was written to them.
- R3: A write with source code 11 leaves the stored source unchanged, still updates the divide field, and sets src_code_err. Once set, src_code_err stays high until reset, including across later valid writes.
- R4: Only the enable input picked by the source code counts toward dot strobes: 00 uses bus_ce, 01 uses per_ce, 10 uses ext_ce. Activity on the other two inputs has no effect on dot_stb.
- R5: With a divide field n in 1..16, dot_stb pulses once for every n selected enables. Each pulse is high in the cycle after the clock edge that sampled the n-th enable.
- R6: A divide field of 0 or of 17..31 acts as divide-by-1, and div_range_err is high while such a value is stored.
- R7: With panel_kind 00 (TFT), shift_stb pulses in the cycle after each dot_stb pulse.
- R8: With panel_kind 01 (monochrome STN), shift_stb pulses once for every W dot pulses, one cycle after the W-th. W is 4, 8 or 16 for bus_width_code 00, 01 or 1x.
- R9: With panel_kind 1x (colour STN), each dot pulse adds 3 to an accumulator. When the sum reaches W, shift_stb pulses one cycle later and W is subtracted, which gives an average rate of 3/W shift pulses per dot.
- R10: A write that changes the stored source or divide field clears the enable counter and the shift accumulator. The next dot pulse then needs a full n selected enables counted after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce | input | 1 | Bus clock enable (source 00) |
| per_ce | input | 1 | Peripheral clock enable (source 01) |
| ext_ce | input | 1 | External clock enable (source 10) |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read data |
| panel_kind | input | 2 | 00 TFT, 01 monochrome STN, 1x colour STN |
| bus_width_code | input | 2 | Panel data bus width: 00 = 4, 01 = 8, 1x = 16 |
| dot_stb | output | 1 | One-cycle dot-rate strobe |
| shift_stb | output | 1 | One-cycle panel shift-rate strobe |
| div_range_err | output | 1 | Stored divide field is outside 1..16 |
| src_code_err | output | 1 | Sticky: prohibited source code was written |

## Verification
The bench runs each panel kind with a different source, divide ratio and bus width. Comparing dot and shift strobes cycle by cycle against an independent model separates the direct TFT path, the one-per-W monochrome rule and the weighted colour accumulator. Non-selected enables are toggled heavily, and dense enables are driven on a sparse selected source, to show that only the chosen source counts. Divide fields of 0 and 20, the prohibited source code, writes with reserved bits set, and a ratio change in the middle of a partial count cover the boundary behaviour.

// File: rtl/lcdclk_pkg.sv
package lcdclk_pkg;

  typedef enum logic [1:0] {
    SRC_BUS = 2'b00,
    SRC_PER = 2'b01,
    SRC_EXT = 2'b10,
    SRC_BAD = 2'b11
  } src_code_t;

  typedef enum logic [1:0] {
    PNL_TFT   = 2'b00,
    PNL_MONO  = 2'b01,
    PNL_COLOR = 2'b10,
    PNL_COLR2 = 2'b11
  } panel_t;

  localparam int SRC_COUNT = 3;

  // Panel data bus width selected by a 2-bit code
  function automatic logic [4:0] bus_width(input logic [1:0] code);
    case (code)
      2'b00:   bus_width = 5'd4;
      2'b01:   bus_width = 5'd8;
      default: bus_width = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/lcdclk_regs.sv
module lcdclk_regs
  import lcdclk_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int DIV_W   = 5,
  parameter int MAX_DIV = 16,
  parameter int SRC_LSB = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [1:0]       src_o,
  output logic [DIV_W-1:0] div_o,
  output logic             chg_o,
  output logic             div_bad_o,
  output logic             src_err_o
);

  logic [1:0]       src_q;
  logic [DIV_W-1:0] div_q;
  logic             chg_q;
  logic             div_bad_q;
  logic             src_err_q;

  logic [1:0]       w_src;
  logic [DIV_W-1:0] w_div;
  logic [1:0]       nxt_src;
  logic             w_bad_src;
  logic             w_div_bad;

  always_comb begin
    w_src     = wdata[SRC_LSB +: 2];
    w_div     = wdata[DIV_W-1:0];
    w_bad_src = (w_src == SRC_BAD);
    nxt_src   = w_bad_src ? src_q : w_src;
    w_div_bad = (w_div == '0) || (w_div > DIV_W'(MAX_DIV));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= SRC_PER;
      div_q     <= DIV_W'(1);
      chg_q     <= 1'b0;
      div_bad_q <= 1'b0;
      src_err_q <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (we) begin
        src_q     <= nxt_src;
        div_q     <= w_div;
        div_bad_q <= w_div_bad;
        chg_q     <= (nxt_src != src_q) || (w_div != div_q);
        if (w_bad_src) src_err_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata                 = '0;
    rdata[SRC_LSB +: 2]   = src_q;
    rdata[DIV_W-1:0]      = div_q;
  end

  assign src_o     = src_q;
  assign div_o     = div_q;
  assign chg_o     = chg_q;
  assign div_bad_o = div_bad_q;
  assign src_err_o = src_err_q;

  // R3: the prohibited code never becomes the stored source
  a_r3_src_never_bad: assert property (@(posedge clk) disable iff (rst)
    src_q != SRC_BAD);

  // R3: error flag is sticky
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
    src_err_q |=> src_err_q);

  // R10: a restart request only follows a write
  a_r10_chg_after_write: assert property (@(posedge clk) disable iff (rst)
    chg_q |-> $past(we));

endmodule

// File: rtl/lcdclk_div.sv
module lcdclk_div
  import lcdclk_pkg::*;
#(
  parameter int DIV_W   = 5,
  parameter int MAX_DIV = 16,
  parameter int N_SRC   = SRC_COUNT,
  localparam int CNT_W  = $clog2(MAX_DIV)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_ce,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             clr,
  output logic             dot_o
);

  logic             sel_ce;
  logic [DIV_W-1:0] ratio;
  logic [CNT_W-1:0] cnt_q;
  logic             dot_q;
  logic             last;

  always_comb begin
    sel_ce = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (src_sel == 2'(i)) sel_ce = src_ce[i];
    end
  end

  always_comb begin
    if (div_val >= DIV_W'(1) && div_val <= DIV_W'(MAX_DIV)) ratio = div_val;
    else ratio = DIV_W'(1);
    last = (DIV_W'(cnt_q) == ratio - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      dot_q <= 1'b0;
    end else begin
      dot_q <= 1'b0;
      if (sel_ce) begin
        if (last) begin
          cnt_q <= '0;
          dot_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign dot_o = dot_q;

  // R5: every dot strobe is caused by a selected enable
  a_r5_dot_after_enable: assert property (@(posedge clk) disable iff (rst)
    dot_q |-> $past(sel_ce));

  // R10: a restart suppresses the strobe
  a_r10_clr_blocks_dot: assert property (@(posedge clk) disable iff (rst)
    clr |=> !dot_q);

endmodule

// File: rtl/lcdclk_shift.sv
module lcdclk_shift
  import lcdclk_pkg::*;
#(
  parameter int ACC_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       dot_i,
  input  logic [1:0] panel,
  input  logic [1:0] wcode,
  output logic       shift_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] width;
  logic [ACC_W-1:0] inc;
  logic [ACC_W:0]   sum;
  logic             shift_q;

  always_comb begin
    width = ACC_W'(bus_width(wcode));
    inc   = (panel == PNL_MONO) ? ACC_W'(1) : ACC_W'(3);
    sum   = {1'b0, acc_q} + {1'b0, inc};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q   <= '0;
      shift_q <= 1'b0;
    end else begin
      shift_q <= 1'b0;
      if (dot_i) begin
        if (panel == PNL_TFT) begin
          shift_q <= 1'b1;
        end else if (sum >= {1'b0, width}) begin
          shift_q <= 1'b1;
          acc_q   <= ACC_W'(sum - {1'b0, width});
        end else begin
          acc_q   <= ACC_W'(sum);
        end
      end
    end
  end

  assign shift_o = shift_q;

  // R7: a shift strobe is always preceded by a dot strobe
  a_r7_shift_after_dot: assert property (@(posedge clk) disable iff (rst)
    shift_q |-> $past(dot_i));

endmodule

// File: rtl/lcd_dotclk_gen.sv
module lcd_dotclk_gen
  import lcdclk_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int DIV_W   = 5,
  parameter int MAX_DIV = 16,
  parameter int SRC_LSB = 12,
  parameter int ACC_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_ce,
  input  logic             per_ce,
  input  logic             ext_ce,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [1:0]       panel_kind,
  input  logic [1:0]       bus_width_code,
  output logic             dot_stb,
  output logic             shift_stb,
  output logic             div_range_err,
  output logic             src_code_err
);

  logic [1:0]           src;
  logic [DIV_W-1:0]     div;
  logic                 chg;
  logic [SRC_COUNT-1:0] ce_vec;
  logic                 dot;

  assign ce_vec = {ext_ce, per_ce, bus_ce};

  lcdclk_regs #(
    .REG_W(REG_W), .DIV_W(DIV_W), .MAX_DIV(MAX_DIV), .SRC_LSB(SRC_LSB)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata), .rdata(reg_rdata),
    .src_o(src), .div_o(div), .chg_o(chg),
    .div_bad_o(div_range_err), .src_err_o(src_code_err)
  );

  lcdclk_div #(
    .DIV_W(DIV_W), .MAX_DIV(MAX_DIV), .N_SRC(SRC_COUNT)
  ) u_div (
    .clk(clk), .rst(rst), .src_ce(ce_vec), .src_sel(src),
    .div_val(div), .clr(chg), .dot_o(dot)
  );

  lcdclk_shift #(
    .ACC_W(ACC_W)
  ) u_shift (
    .clk(clk), .rst(rst), .clr(chg), .dot_i(dot),
    .panel(panel_kind), .wcode(bus_width_code), .shift_o(shift_stb)
  );

  assign dot_stb = dot;

endmodule

// File: tb/lcd_dotclk_gen_test.sv
`timescale 1ns/1ps
module lcd_dotclk_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_ce = 0, per_ce = 0, ext_ce = 0;
  logic        reg_we = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  panel_kind = 2'b00, bus_width_code = 2'b00;
  logic        dot_stb, shift_stb, div_range_err, src_code_err;

  lcd_dotclk_gen uut (
    .clk(clk), .rst(rst), .bus_ce(bus_ce), .per_ce(per_ce), .ext_ce(ext_ce),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .panel_kind(panel_kind), .bus_width_code(bus_width_code),
    .dot_stb(dot_stb), .shift_stb(shift_stb),
    .div_range_err(div_range_err), .src_code_err(src_code_err)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic  d;
    logic  s;
    string tag;
  } exp_t;

  exp_t  sb[$];
  exp_t  pend;
  bit    pend_v = 0;
  int    total = 0, bad = 0;
  string cur_tag = "R7";
  bit    done = 0;

  // bench model state
  int    m_src = 1, m_div = 1, m_cnt = 0, m_acc = 0;
  logic  m_prev = 0;

  function automatic int ratio_of(int d);
    return (d >= 1 && d <= 16) ? d : 1;
  endfunction

  function automatic int width_of(logic [1:0] c);
    return (c == 2'b00) ? 4 : (c == 2'b01) ? 8 : 16;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      total++;
      if (dot_stb !== it.d || shift_stb !== it.s) begin
        bad++;
        $display("FAIL %s actual dot=%b shift=%b expected dot=%b shift=%b",
                 it.tag, dot_stb, shift_stb, it.d, it.s);
      end
    end
  end

  task automatic step(logic b, logic p, logic e);
    logic sel, de, se;
    int inc;
    @(posedge clk); #2;
    if (pend_v) sb.push_back(pend);
    bus_ce = b; per_ce = p; ext_ce = e;
    sel = (m_src == 0) ? b : (m_src == 1) ? p : e;
    de = 0; se = 0;
    if (sel) begin
      if (m_cnt == ratio_of(m_div) - 1) begin de = 1; m_cnt = 0; end
      else m_cnt++;
    end
    if (m_prev) begin
      if (panel_kind == 2'b00) se = 1;
      else begin
        inc = (panel_kind == 2'b01) ? 1 : 3;
        m_acc += inc;
        if (m_acc >= width_of(bus_width_code)) begin
          se = 1; m_acc -= width_of(bus_width_code);
        end
      end
    end
    m_prev = de;
    pend.d = de; pend.s = se; pend.tag = cur_tag;
    pend_v = 1;
  endtask

  task automatic flush();
    step(0, 0, 0);
    step(0, 0, 0);
    @(posedge clk); #2;
    if (pend_v) sb.push_back(pend);
    pend_v = 0;
    bus_ce = 0; per_ce = 0; ext_ce = 0;
  endtask

  // call only after flush (positioned just past a clock edge)
  task automatic wr(logic [15:0] v);
    int ns;
    reg_we = 1; reg_wdata = v;
    @(posedge clk); #2;
    reg_we = 0;
    ns = (v[13:12] == 2'b11) ? m_src : int'(v[13:12]);
    if (ns != m_src || int'(v[4:0]) != m_div) begin
      m_cnt = 0; m_acc = 0;
    end
    m_src = ns; m_div = int'(v[4:0]);
    @(posedge clk); #2;
  endtask

  task automatic run(int n, int pct, int other_pct);
    for (int i = 0; i < n; i++) begin
      logic b, p, e, s;
      s = (($urandom % 100) < pct);
      b = (($urandom % 100) < other_pct);
      p = (($urandom % 100) < other_pct);
      e = (($urandom % 100) < other_pct);
      if (m_src == 0) b = s; else if (m_src == 1) p = s; else e = s;
      step(b, p, e);
    end
    flush();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    chk("R1 rdata", reg_rdata, 16'h1001);
    chk("R1 dot", {15'b0, dot_stb}, 16'h0);
    chk("R1 shift", {15'b0, shift_stb}, 16'h0);
    chk("R1 flags", {14'b0, div_range_err, src_code_err}, 16'h0);

    // R7: TFT at reset settings (peripheral, divide 1)
    @(posedge clk); #2;
    cur_tag = "R7";
    run(40, 70, 50);

    // R8: bus source, divide 5, monochrome, width 4
    panel_kind = 2'b01; bus_width_code = 2'b00;
    wr(16'h0005);
    chk("R2 rdata", reg_rdata, 16'h0005);
    cur_tag = "R8";
    run(150, 80, 50);

    // R9: external source, divide 16, colour, width 8
    panel_kind = 2'b10; bus_width_code = 2'b01;
    wr(16'h2010);
    chk("R2 rdata", reg_rdata, 16'h2010);
    cur_tag = "R9";
    run(400, 90, 50);

    // R4: peripheral divide 3, others always active, selected sparse
    panel_kind = 2'b00;
    wr(16'h1003);
    cur_tag = "R4";
    run(80, 30, 100);

    // R6: divide field 0, then 20
    panel_kind = 2'b01; bus_width_code = 2'b10;
    wr(16'h2000);
    chk("R6 div_range_err", {15'b0, div_range_err}, 16'h1);
    cur_tag = "R6";
    run(80, 60, 50);
    panel_kind = 2'b11; bus_width_code = 2'b00;
    wr(16'h2014);
    chk("R6 div_range_err", {15'b0, div_range_err}, 16'h1);
    run(60, 60, 50);

    // R2: reserved bits written as ones; R5 with divide 10
    panel_kind = 2'b00;
    wr(16'hCFEA);
    chk("R2 reserved", reg_rdata, 16'h000A);
    chk("R6 cleared", {15'b0, div_range_err}, 16'h0);
    cur_tag = "R5";
    run(100, 80, 50);

    // R3: prohibited source code
    wr(16'h3003);
    chk("R3 src kept", reg_rdata, 16'h0003);
    chk("R3 err set", {15'b0, src_code_err}, 16'h1);
    cur_tag = "R3";
    run(40, 70, 50);
    wr(16'h1007);
    chk("R3 sticky rdata", reg_rdata, 16'h1007);
    chk("R3 err sticky", {15'b0, src_code_err}, 16'h1);

    // R10: partial count at divide 7, then change to 12
    cur_tag = "R10";
    panel_kind = 2'b10; bus_width_code = 2'b11;
    for (int i = 0; i < 10; i++) step(0, 1, 0);
    flush();
    wr(16'h100C);
    run(60, 100, 50);

    @(posedge clk); @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule